// File: doc/BRIEF.md
# Miss-Driven Stream Prefetcher

This block sits beside a cache and listens to its miss traffic. Every miss becomes a demand block request to the next memory level in the following cycle. The block also generates speculative block requests that only use cycles the demand traffic leaves free.

Instruction misses always schedule the block right after the missed one. That block is parked in a one-entry side buffer and is not written into the cache. A later instruction miss on the parked block is answered from the buffer, with no memory request. Any other instruction miss discards the parked block.

Data misses are grouped by 4 KB page in a table of up to eight streams. A page starts streaming when two back-to-back misses on it land on different blocks less than 256 bytes apart. The sign and size of the step between those two misses set the direction and stride of the prefetches. Each further miss on the page re-arms a small number of requests ahead of it. A stream whose next address would leave its page is dropped.

Top module: `stream_prefetcher`

## Requirements
- R1: During and directly after synchronous reset, `req_vld` and `buf_hit` are 0, and the stream table and side buffer hold nothing.
- R2: A miss that is not answered by the side buffer produces, one cycle later, `req_vld`=1, `req_pf`=0, `req_blk` equal to the missed block, and `req_instr` equal to the miss kind (1 = instruction, 0 = data).
- R3: An instruction miss on block A schedules a prefetch of block A+1, issued with `req_pf`=1 and `req_instr`=1. Once issued, A+1 becomes the block held in the side buffer.
- R4: An instruction miss whose block equals the side-buffer block gives `buf_hit`=1 and `req_vld`=0 one cycle later, and empties the buffer.
- R5: An instruction miss that does not match the side buffer empties it, so a later miss on the formerly held block is a demand request.
- R6: A prefetch is issued only in a cycle with no miss and `mem_rdy`=1. A demand request always wins the cycle, and a pending instruction prefetch wins over data prefetches.
- R7: A data stream is started on a page only when two successive data misses to that page differ by at least one block and by fewer than 256 bytes. A distance of 256 bytes or more starts nothing.
- R8: A started stream steps from the newest miss by the distance of the triggering pair, up or down in its direction. It issues at most 2 prefetches after each data miss to its page, with the lowest-numbered ready stream served first.
- R9: A stream whose next prefetch address lies outside its 4 KB page issues no request for it and is retired, so its page is forgotten.
- R10: The table tracks 8 pages. A data miss to an untracked page takes a free slot; if none is free, it takes the slot least recently allocated or triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_vld | input | 1 | A cache miss is presented this cycle |
| miss_instr | input | 1 | 1 = instruction miss, 0 = data miss |
| miss_blk | input | 26 | Block address of the miss (byte address without block offset) |
| mem_rdy | input | 1 | Memory has spare bandwidth for a prefetch this cycle |
| req_vld | output | 1 | Registered block request to memory |
| req_pf | output | 1 | Request is a prefetch (1) or demand (0) |
| req_instr | output | 1 | Request belongs to the instruction side |
| req_blk | output | 26 | Requested block address |
| buf_hit | output | 1 | Previous cycle's instruction miss was served from the side buffer |

## Verification
The cycle after a data stream fires is also a likely cycle for a new miss, so demand issue and prefetch issue compete for the single request slot. The bench provokes this by placing an instruction miss directly after the triggering data miss, and then dropping `mem_rdy` while a prefetch is pending. It judges the result by the exact order in which requests appear: the demand first, then the sequential instruction block, then the data stream blocks, with nothing in the cycle where `mem_rdy` is low.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  // Which producer owns the request slot in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEM  = 2'd1,
    SRC_IPF  = 2'd2,
    SRC_DPF  = 2'd3
  } req_src_e;
endpackage

// File: rtl/pfe_stream_table.sv
module pfe_stream_table #(
  parameter int BA_W      = 26,
  parameter int OFF_W     = 6,
  parameter int NSTR      = 8,
  parameter int NEAR_BLKS = 4,
  parameter int DEPTH     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            d_miss,
  input  logic [BA_W-1:0] miss_blk,
  input  logic            dpf_take,
  output logic            dpf_vld,
  output logic [BA_W-1:0] dpf_blk
);
  localparam int PG_W  = BA_W - OFF_W;
  localparam int IDX_W = (NSTR > 1) ? $clog2(NSTR) : 1;
  localparam int CR_W  = $clog2(DEPTH + 1);
  typedef logic [OFF_W:0] ext_t;

  logic             e_vld  [NSTR];
  logic             e_act  [NSTR];
  logic [PG_W-1:0]  e_page [NSTR];
  logic [OFF_W-1:0] e_last [NSTR];
  logic             e_dir  [NSTR];
  logic [OFF_W-1:0] e_str  [NSTR];
  ext_t             e_nxt  [NSTR];
  logic [CR_W-1:0]  e_cr   [NSTR];
  logic [IDX_W-1:0] e_rank [NSTR];

  logic [PG_W-1:0]  m_page;
  logic [OFF_W-1:0] m_off;
  assign m_page = miss_blk[BA_W-1:OFF_W];
  assign m_off  = miss_blk[OFF_W-1:0];

  function automatic ext_t step_off(input logic [OFF_W-1:0] o, input logic dn,
                                    input logic [OFF_W-1:0] s);
    step_off = dn ? ({1'b0, o} - {1'b0, s}) : ({1'b0, o} + {1'b0, s});
  endfunction

  logic             hit_any, free_any, sel_any;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, sel_idx, alloc_idx, touch_idx;
  logic [NSTR-1:0]  is_lru, out_vec;

  genvar g;
  generate
    for (g = 0; g < NSTR; g++) begin : g_flags
      assign is_lru[g]  = (e_rank[g] == '0);
      assign out_vec[g] = e_vld[g] && e_act[g] && e_nxt[g][OFF_W];
      // R7: an active stream always carries a near, nonzero stride
      p_stride_near_r7: assert property (@(posedge clk) disable iff (rst)
        e_act[g] |-> (e_str[g] != '0 && e_str[g] < NEAR_BLKS));
    end
  endgenerate

  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    free_any = 1'b0; free_idx = '0;
    lru_idx = '0;
    sel_any = 1'b0; sel_idx = '0;
    for (int i = NSTR - 1; i >= 0; i--) begin
      if (e_vld[i] && e_page[i] == m_page) begin hit_any = 1'b1; hit_idx = IDX_W'(i); end
      if (!e_vld[i]) begin free_any = 1'b1; free_idx = IDX_W'(i); end
      if (is_lru[i]) lru_idx = IDX_W'(i);
      if (e_vld[i] && e_act[i] && e_cr[i] != '0 && !e_nxt[i][OFF_W]) begin
        sel_any = 1'b1; sel_idx = IDX_W'(i);
      end
    end
  end

  ext_t diff, mag;
  logic dn, near, touch_en;
  always_comb begin
    diff      = {1'b0, m_off} - {1'b0, e_last[hit_idx]};
    dn        = diff[OFF_W];
    mag       = dn ? (~diff + ext_t'(1)) : diff;
    near      = (mag != '0) && (mag < ext_t'(NEAR_BLKS));
    alloc_idx = free_any ? free_idx : lru_idx;
    touch_idx = hit_any ? hit_idx : alloc_idx;
    touch_en  = d_miss && (!hit_any || (!e_act[hit_idx] && near));
  end

  assign dpf_vld = sel_any;
  assign dpf_blk = {e_page[sel_idx], e_nxt[sel_idx][OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTR; i++) begin
        e_vld[i]  <= 1'b0;
        e_act[i]  <= 1'b0;
        e_page[i] <= '0;
        e_last[i] <= '0;
        e_dir[i]  <= 1'b0;
        e_str[i]  <= '0;
        e_nxt[i]  <= '0;
        e_cr[i]   <= '0;
        e_rank[i] <= IDX_W'(i);
      end
    end else begin
      // retire streams whose next block leaves the page
      for (int i = 0; i < NSTR; i++) begin
        if (out_vec[i]) begin
          e_vld[i] <= 1'b0;
          e_act[i] <= 1'b0;
        end
      end
      if (touch_en) begin
        for (int j = 0; j < NSTR; j++) begin
          if (IDX_W'(j) == touch_idx) e_rank[j] <= IDX_W'(NSTR - 1);
          else if (e_rank[j] > e_rank[touch_idx]) e_rank[j] <= e_rank[j] - 1'b1;
        end
      end
      if (dpf_take && sel_any) begin
        e_nxt[sel_idx] <= step_off(e_nxt[sel_idx][OFF_W-1:0], e_dir[sel_idx], e_str[sel_idx]);
        e_cr[sel_idx]  <= e_cr[sel_idx] - 1'b1;
      end
      if (d_miss) begin
        if (hit_any) begin
          e_last[hit_idx] <= m_off;
          if (e_act[hit_idx]) begin
            e_nxt[hit_idx] <= step_off(m_off, e_dir[hit_idx], e_str[hit_idx]);
            e_cr[hit_idx]  <= CR_W'(DEPTH);
          end else if (near) begin
            e_act[hit_idx] <= 1'b1;
            e_dir[hit_idx] <= dn;
            e_str[hit_idx] <= mag[OFF_W-1:0];
            e_nxt[hit_idx] <= step_off(m_off, dn, mag[OFF_W-1:0]);
            e_cr[hit_idx]  <= CR_W'(DEPTH);
          end
        end else begin
          e_vld[alloc_idx]  <= 1'b1;
          e_act[alloc_idx]  <= 1'b0;
          e_page[alloc_idx] <= m_page;
          e_last[alloc_idx] <= m_off;
          e_cr[alloc_idx]   <= '0;
        end
      end
    end
  end

  // R10: the replacement order always names exactly one oldest slot
  p_one_lru_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(is_lru) == 1);
  // R6: a data prefetch is only taken when one is offered
  p_take_offered_r6: assert property (@(posedge clk) disable iff (rst)
    dpf_take |-> dpf_vld);
endmodule

// File: rtl/pfe_sbuf.sv
module pfe_sbuf #(
  parameter int BA_W = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_miss,
  input  logic [BA_W-1:0] miss_blk,
  input  logic            ipf_take,
  output logic            sb_match,
  output logic            ipf_vld,
  output logic [BA_W-1:0] ipf_blk
);
  logic            sb_vld;
  logic [BA_W-1:0] sb_blk;
  logic            pend_vld;
  logic [BA_W-1:0] pend_blk;

  assign sb_match = i_miss && sb_vld && (sb_blk == miss_blk);
  assign ipf_vld  = pend_vld;
  assign ipf_blk  = pend_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_vld   <= 1'b0;
      sb_blk   <= '0;
      pend_vld <= 1'b0;
      pend_blk <= '0;
    end else if (i_miss) begin
      // matching block moves to the cache, any other miss drops it
      sb_vld   <= 1'b0;
      pend_vld <= 1'b1;
      pend_blk <= miss_blk + 1'b1;
    end else if (ipf_take) begin
      sb_vld   <= 1'b1;
      sb_blk   <= pend_blk;
      pend_vld <= 1'b0;
    end
  end

  // R4: a buffer hit empties the buffer
  p_hit_consumes_r4: assert property (@(posedge clk) disable iff (rst)
    sb_match |=> !sb_vld);
  // R3: an issued sequential prefetch lands in the buffer
  p_fill_lands_r3: assert property (@(posedge clk) disable iff (rst)
    ipf_take |=> (sb_vld && sb_blk == $past(pend_blk)));
endmodule

// File: rtl/pfe_req_arb.sv
module pfe_req_arb
  import pfe_pkg::*;
#(
  parameter int BA_W = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            miss_vld,
  input  logic            miss_instr,
  input  logic [BA_W-1:0] miss_blk,
  input  logic            sb_match,
  input  logic            mem_rdy,
  input  logic            ipf_vld,
  input  logic [BA_W-1:0] ipf_blk,
  input  logic            dpf_vld,
  input  logic [BA_W-1:0] dpf_blk,
  output logic            ipf_take,
  output logic            dpf_take,
  output logic            req_vld,
  output logic            req_pf,
  output logic            req_instr,
  output logic [BA_W-1:0] req_blk,
  output logic            buf_hit
);
  req_src_e src;

  always_comb begin
    if (miss_vld)     src = sb_match ? SRC_NONE : SRC_DEM;
    else if (!mem_rdy) src = SRC_NONE;
    else if (ipf_vld)  src = SRC_IPF;
    else if (dpf_vld)  src = SRC_DPF;
    else               src = SRC_NONE;
  end

  assign ipf_take = (src == SRC_IPF);
  assign dpf_take = (src == SRC_DPF);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_vld   <= 1'b0;
      req_pf    <= 1'b0;
      req_instr <= 1'b0;
      req_blk   <= '0;
      buf_hit   <= 1'b0;
    end else begin
      req_vld <= (src != SRC_NONE);
      req_pf  <= (src == SRC_IPF) || (src == SRC_DPF);
      buf_hit <= sb_match;
      unique case (src)
        SRC_DEM: begin req_instr <= miss_instr; req_blk <= miss_blk; end
        SRC_IPF: begin req_instr <= 1'b1;       req_blk <= ipf_blk;  end
        SRC_DPF: begin req_instr <= 1'b0;       req_blk <= dpf_blk;  end
        default: begin req_instr <= 1'b0;       req_blk <= '0;       end
      endcase
    end
  end

  // R6: prefetches only ride on spare cycles
  p_pf_spare_r6: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_pf) |-> $past(!miss_vld && mem_rdy));
  // R2: an unserved miss is requested in the next cycle
  p_demand_next_r2: assert property (@(posedge clk) disable iff (rst)
    (miss_vld && !sb_match) |=> (req_vld && !req_pf && req_blk == $past(miss_blk)));
  // R4: a buffer hit never coincides with a request
  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    buf_hit |-> !req_vld);
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int BLK_W      = 6,
  parameter int PAGE_W     = 12,
  parameter int NSTR       = 8,
  parameter int NEAR_BYTES = 256,
  parameter int DEPTH      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_vld,
  input  logic                    miss_instr,
  input  logic [ADDR_W-BLK_W-1:0] miss_blk,
  input  logic                    mem_rdy,
  output logic                    req_vld,
  output logic                    req_pf,
  output logic                    req_instr,
  output logic [ADDR_W-BLK_W-1:0] req_blk,
  output logic                    buf_hit
);
  localparam int BA_W      = ADDR_W - BLK_W;
  localparam int OFF_W     = PAGE_W - BLK_W;
  localparam int NEAR_BLKS = NEAR_BYTES >> BLK_W;

  logic            sb_match, ipf_vld, ipf_take, dpf_vld, dpf_take;
  logic [BA_W-1:0] ipf_blk, dpf_blk;

  pfe_sbuf #(.BA_W(BA_W)) u_sbuf (
    .clk      (clk),
    .rst      (rst),
    .i_miss   (miss_vld && miss_instr),
    .miss_blk (miss_blk),
    .ipf_take (ipf_take),
    .sb_match (sb_match),
    .ipf_vld  (ipf_vld),
    .ipf_blk  (ipf_blk)
  );

  pfe_stream_table #(
    .BA_W(BA_W), .OFF_W(OFF_W), .NSTR(NSTR), .NEAR_BLKS(NEAR_BLKS), .DEPTH(DEPTH)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .d_miss   (miss_vld && !miss_instr),
    .miss_blk (miss_blk),
    .dpf_take (dpf_take),
    .dpf_vld  (dpf_vld),
    .dpf_blk  (dpf_blk)
  );

  pfe_req_arb #(.BA_W(BA_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .miss_vld   (miss_vld),
    .miss_instr (miss_instr),
    .miss_blk   (miss_blk),
    .sb_match   (sb_match),
    .mem_rdy    (mem_rdy),
    .ipf_vld    (ipf_vld),
    .ipf_blk    (ipf_blk),
    .dpf_vld    (dpf_vld),
    .dpf_blk    (dpf_blk),
    .ipf_take   (ipf_take),
    .dpf_take   (dpf_take),
    .req_vld    (req_vld),
    .req_pf     (req_pf),
    .req_instr  (req_instr),
    .req_blk    (req_blk),
    .buf_hit    (buf_hit)
  );
endmodule

// File: tb/tb_stream_prefetcher.sv
`timescale 1ns/1ps
module tb_stream_prefetcher;
  logic        clk = 1'b0;
  logic        rst;
  logic        miss_vld, miss_instr, mem_rdy;
  logic [25:0] miss_blk;
  logic        req_vld, req_pf, req_instr, buf_hit;
  logic [25:0] req_blk;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stream_prefetcher dut (
    .clk(clk), .rst(rst), .miss_vld(miss_vld), .miss_instr(miss_instr),
    .miss_blk(miss_blk), .mem_rdy(mem_rdy), .req_vld(req_vld), .req_pf(req_pf),
    .req_instr(req_instr), .req_blk(req_blk), .buf_hit(buf_hit)
  );

  // row: req[62:59] mv mi blk[26] rdy | ev ep ei eblk[26] ehit
  localparam logic [25:0] Z = 26'h0;
  localparam int NV = 34;
  localparam logic [62:0] VEC [NV] = '{
    {4'd2, 1'b1,1'b1,26'h4000,1'b1, 1'b1,1'b0,1'b1,26'h4000,1'b0}, // R2 instr demand
    {4'd3, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b1,26'h4001,1'b0}, // R3 next block
    {4'd6, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R6 nothing left
    {4'd4, 1'b1,1'b1,26'h4001,1'b1, 1'b0,1'b0,1'b0,Z,1'b1},        // R4 buffer hit
    {4'd3, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b1,26'h4002,1'b0}, // R3
    {4'd2, 1'b1,1'b1,26'h5000,1'b1, 1'b1,1'b0,1'b1,26'h5000,1'b0}, // R2
    {4'd6, 1'b0,1'b0,Z,1'b0,        1'b0,1'b0,1'b0,Z,1'b0},        // R6 no spare slot
    {4'd6, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b1,26'h5001,1'b0}, // R6 slot returns
    {4'd5, 1'b1,1'b1,26'h4002,1'b1, 1'b1,1'b0,1'b1,26'h4002,1'b0}, // R5 mismatch drops
    {4'd5, 1'b1,1'b1,26'h5001,1'b1, 1'b1,1'b0,1'b1,26'h5001,1'b0}, // R5 was dropped
    {4'd3, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b1,26'h5002,1'b0}, // R3
    {4'd2, 1'b1,1'b0,26'h8010,1'b1, 1'b1,1'b0,1'b0,26'h8010,1'b0}, // R2 data demand
    {4'd7, 1'b1,1'b0,26'h8012,1'b1, 1'b1,1'b0,1'b0,26'h8012,1'b0}, // R7 128B trigger
    {4'd6, 1'b1,1'b1,26'h6000,1'b1, 1'b1,1'b0,1'b1,26'h6000,1'b0}, // R6 demand wins
    {4'd6, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b1,26'h6001,1'b0}, // R6 instr pf first
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'h8014,1'b0}, // R8 stride up
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'h8016,1'b0}, // R8
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R8 depth used
    {4'd8, 1'b1,1'b0,26'h8018,1'b1, 1'b1,1'b0,1'b0,26'h8018,1'b0}, // R8 re-arm
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'h801A,1'b0}, // R8 from last miss
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'h801C,1'b0}, // R8
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R8
    {4'd2, 1'b1,1'b0,26'hC000,1'b1, 1'b1,1'b0,1'b0,26'hC000,1'b0}, // R2
    {4'd7, 1'b1,1'b0,26'hC004,1'b1, 1'b1,1'b0,1'b0,26'hC004,1'b0}, // R7 256B apart
    {4'd7, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R7 no stream
    {4'd8, 1'b1,1'b0,26'hC002,1'b1, 1'b1,1'b0,1'b0,26'hC002,1'b0}, // R8 downward
    {4'd8, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'hC000,1'b0}, // R8 step down
    {4'd9, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R9 below page
    {4'd2, 1'b1,1'b0,26'h1003D,1'b1,1'b1,1'b0,1'b0,26'h1003D,1'b0},// R2
    {4'd9, 1'b1,1'b0,26'h1003F,1'b1,1'b1,1'b0,1'b0,26'h1003F,1'b0},// R9 trigger at top
    {4'd9, 1'b0,1'b0,Z,1'b1,        1'b0,1'b0,1'b0,Z,1'b0},        // R9 above page
    {4'd2, 1'b1,1'b0,26'h14010,1'b1,1'b1,1'b0,1'b0,26'h14010,1'b0},// R2
    {4'd7, 1'b1,1'b0,26'h14013,1'b1,1'b1,1'b0,1'b0,26'h14013,1'b0},// R7 192B trigger
    {4'd7, 1'b0,1'b0,Z,1'b1,        1'b1,1'b1,1'b0,26'h14016,1'b0} // R7 stride 3
  };

  task automatic drive(input logic mv, input logic mi, input logic [25:0] b, input logic rdy);
    miss_vld = mv; miss_instr = mi; miss_blk = b; mem_rdy = rdy;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic ev, input logic ep, input logic ei,
                            input logic [25:0] eb, input logic eh);
    checks++;
    if (req_vld !== ev || buf_hit !== eh ||
        (ev && (req_pf !== ep || req_instr !== ei || req_blk !== eb))) begin
      errors++;
      $display("FAIL %s: got vld=%0b pf=%0b instr=%0b blk=%h hit=%0b, expected vld=%0b pf=%0b instr=%0b blk=%h hit=%0b",
               tag, req_vld, req_pf, req_instr, req_blk, buf_hit, ev, ep, ei, eb, eh);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(1'b0, 1'b0, Z, 1'b1);
    drive(1'b0, 1'b0, Z, 1'b1);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    miss_vld = 1'b0; miss_instr = 1'b0; miss_blk = Z; mem_rdy = 1'b1;
    do_reset();
    expect_out("R1 reset state", 1'b0, 1'b0, 1'b0, Z, 1'b0);
    drive(1'b0, 1'b0, Z, 1'b1);
    expect_out("R1 idle after reset", 1'b0, 1'b0, 1'b0, Z, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      drive(v[58], v[57], v[56:31], v[30]);
      expect_out($sformatf("R%0d row %0d", v[62:59], i), v[29], v[28], v[27], v[26:1], v[0]);
    end

    // R10: nine pages through eight slots; page 1 is the oldest and is replaced
    do_reset();
    for (int p = 1; p <= 9; p++) drive(1'b1, 1'b0, 26'(p << 6), 1'b1);
    expect_out("R10 ninth page demand", 1'b1, 1'b0, 1'b0, 26'h240, 1'b0);
    drive(1'b1, 1'b0, 26'h82, 1'b1);   // page 2 still tracked: triggers
    expect_out("R10 kept page demand", 1'b1, 1'b0, 1'b0, 26'h82, 1'b0);
    drive(1'b0, 1'b0, Z, 1'b1);
    expect_out("R10 kept page streams", 1'b1, 1'b1, 1'b0, 26'h84, 1'b0);
    drive(1'b1, 1'b0, 26'h42, 1'b1);   // page 1 was replaced: fresh slot, no trigger
    expect_out("R10 replaced page demand", 1'b1, 1'b0, 1'b0, 26'h42, 1'b0);
    drive(1'b0, 1'b0, Z, 1'b1);
    expect_out("R10 only kept stream", 1'b1, 1'b1, 1'b0, 26'h86, 1'b0);
    drive(1'b0, 1'b0, Z, 1'b1);
    expect_out("R10 replaced page silent", 1'b0, 1'b0, 1'b0, Z, 1'b0);

    // R1: reset in the middle of a stream clears pending work
    drive(1'b1, 1'b1, 26'h300, 1'b1);
    do_reset();
    drive(1'b0, 1'b0, Z, 1'b1);
    expect_out("R1 pending cleared", 1'b0, 1'b0, 1'b0, Z, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule